// File: doc/BRIEF.md
# Power-on reset release sequencer

This block decides when a chip may leave power-on reset. While the active-low external power-on reset input is low, every reset output it drives is held asserted and every clock enable is held off. Once that input goes high, the block first frees the fuse array. It then holds the global power-on and warm resets until six hardware readiness flags have all been high together for a programmable number of clock edges. The flags are the three domain rail-good flags, clock-stable, memory-regulator-ready and fuse-ready.

After the global release, the block walks a fixed chain of ten steps, one per clock edge. The steps interleave reset releases with clock-gate enables and end with the processor boot enable. A sticky status flag records that boot was reached. Two kinds of domain are released only on software request, and only after the core reset is released: the signal-processor domain, and a set of peripheral domains (display, camera, graphics, vector unit). Rails, regulators, oscillators and PLLs are not modelled; they appear only as the ready flags.

Top module: `por_release_seq`

## Requirements
- R1: While `ext_por_n` is low, every output is 0. When `ext_por_n` falls, whatever the state, all outputs go to 0 at once, without waiting for a clock edge.
- R2: Call the first rising clock edge with `ext_por_n` high E0. At E0, `fuse_rst_n` goes to 1. `glob_por_rst_n` and `glob_warm_rst_n` stay 0 at E0.
- R3: Let N = `rst_time`, or N = 1 when `rst_time` is 0. If all six ready flags are high from E1 onward, both global resets go to 1 at edge E_N.
- R4: If any ready flag is low at edge E_d, with d ≤ N, the wait count restarts. The global resets then go to 1 at edge E_(d+N), provided the flags stay high after E_d.
- R5: Starting on the edge after the global release, exactly one chain output goes from 0 to 1 on each edge. The order, which is also the bit index 0..9 of the chain view, is: `pm_rst_n`, `sysclk_en`, `ret_rst_n`, `pll_rst_n`, `corepll_clk_en`, `ic_clk_en`, `procpll_clk_en`, `core_rst_n`, `proc_clk_en`, `boot_en`.
- R6: Once the global resets are released, a ready flag that drops changes no output.
- R7: `booted` goes to 1 one edge after `boot_en` goes to 1. It stays at 1 until `ext_por_n` goes low.
- R8: `dsp_rst_n` is 0 whenever `core_rst_n` is 0. Otherwise, on each edge it takes the value of the inverse of `sw_dsp_hold` (1 = keep the domain in reset).
- R9: `dom_rst_n[i]` is 0 whenever `core_rst_n` is 0. Otherwise, on each edge it takes the value of `sw_if_clk_en[i]`. Bit order is display 0, camera 1, graphics 2, vector unit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_por_n | input | 1 | External power-on reset, active low, asynchronous assert |
| rail_proc_ok | input | 1 | Processor domain voltage stable |
| rail_core_ok | input | 1 | Core domain voltage stable |
| rail_wkup_ok | input | 1 | Wake-up domain voltage stable |
| clk_stable | input | 1 | System clock stable |
| memreg_ok | input | 1 | Internal memory regulators stable |
| fuse_ready | input | 1 | Fuse array ready |
| rst_time | input | RT_W | Reset-time wait length in edges (0 means 1) |
| sw_dsp_hold | input | 1 | Software hold of the signal-processor domain reset |
| sw_if_clk_en | input | NUM_SW_DOM | Software interface clock enables, one per peripheral domain |
| fuse_rst_n | output | 1 | Fuse array reset, active low |
| glob_por_rst_n | output | 1 | Global power-on reset, active low |
| glob_warm_rst_n | output | 1 | Global warm reset, active low |
| pm_rst_n | output | 1 | Power-manager reset, active low |
| sysclk_en | output | 1 | System clock gate enable |
| ret_rst_n | output | 1 | Retention clock-manager reset, active low |
| pll_rst_n | output | 1 | PLL reset, active low |
| corepll_clk_en | output | 1 | Core PLL clock gate enable |
| ic_clk_en | output | 1 | Interconnect clock enable |
| procpll_clk_en | output | 1 | Processor PLL clock gate enable |
| core_rst_n | output | 1 | Core reset, active low |
| proc_clk_en | output | 1 | Processor clock enable |
| boot_en | output | 1 | Processor boot enable |
| booted | output | 1 | Sticky flag: boot was enabled |
| dsp_rst_n | output | 1 | Signal-processor domain reset, active low |
| dom_rst_n | output | NUM_SW_DOM | Peripheral domain resets, active low |

## Verification
The fuse release is due at the first edge after `ext_por_n` rises. The global release is due N edges after that, or d+N edges when a flag is dropped at edge d. Chain step k is due k edges after the global release, and `booted` one edge after the last step. The software-gated domain resets follow their request with one edge of delay. The bench drives every input at a falling edge and samples at the next falling edge. It therefore reads each result exactly one rising edge after the edge that should produce it, and it counts falling edges to find the edge where the global release appears. The asynchronous return to reset is checked one nanosecond after `ext_por_n` falls, between clock edges.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  localparam int unsigned CHAIN_LEN   = 10;
  localparam int unsigned IDX_PM      = 0;
  localparam int unsigned IDX_SYSCLK  = 1;
  localparam int unsigned IDX_RET     = 2;
  localparam int unsigned IDX_PLL     = 3;
  localparam int unsigned IDX_COREPLL = 4;
  localparam int unsigned IDX_IC      = 5;
  localparam int unsigned IDX_PROCPLL = 6;
  localparam int unsigned IDX_CORE    = 7;
  localparam int unsigned IDX_PROCCLK = 8;
  localparam int unsigned IDX_BOOT    = 9;

  // Number of consecutive all-ready edges needed; a zero field waits one edge.
  function automatic int unsigned hold_edges(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction

endpackage

// File: rtl/por_hold_timer.sv
module por_hold_timer #(
  parameter int unsigned RT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            all_ready,
  input  logic [RT_W-1:0] rst_time,
  output logic            expire
);
  import por_seq_pkg::*;

  logic [RT_W-1:0] cnt_q;
  logic [RT_W-1:0] last_cnt;

  assign last_cnt = RT_W'(hold_edges(32'(rst_time)) - 1);
  assign expire   = active && all_ready && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || !all_ready) begin
      cnt_q <= '0;
    end else if (!expire) begin
      cnt_q <= cnt_q + RT_W'(1);
    end
  end

  // R4: a missing flag leaves the counter at its start on the next edge
  p_clear_on_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !all_ready) |=> (cnt_q == '0))
    else $error("p_clear_on_drop_r4");

endmodule

// File: rtl/por_release_chain.sv
module por_release_chain #(
  parameter int unsigned LEN = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  output logic [LEN-1:0] rel,
  output logic           done
);

  logic [LEN-1:0] rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= '0;
    end else if (advance && !rel_q[LEN-1]) begin
      rel_q <= {rel_q[LEN-2:0], 1'b1};
    end
  end

  assign rel  = rel_q;
  assign done = rel_q[LEN-1];

  generate
    for (genvar g = 1; g < LEN; g++) begin : g_order
      // R5: a later stage is never on while an earlier one is off
      p_stage_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q[g] |-> rel_q[g-1])
        else $error("p_stage_order_r5");
    end
  endgenerate

  // R5: at most one stage changes per edge
  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rel_q ^ $past(rel_q)) <= 1)
    else $error("p_one_step_r5");

endmodule

// File: rtl/por_domain_gate.sv
module por_domain_gate #(
  parameter int unsigned NUM_DOM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_up,
  input  logic               dsp_hold,
  input  logic [NUM_DOM-1:0] if_clk_en,
  output logic               dsp_rst_n,
  output logic [NUM_DOM-1:0] dom_rst_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsp_rst_n <= 1'b0;
    end else begin
      dsp_rst_n <= core_up && !dsp_hold;
    end
  end

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dom_rst_n[d] <= 1'b0;
        end else begin
          dom_rst_n[d] <= core_up && if_clk_en[d];
        end
      end
    end
  endgenerate

  // R8: no signal-processor release before the core is out of reset
  p_dsp_after_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_up |=> !dsp_rst_n)
    else $error("p_dsp_after_core_r8");

  // R9: no peripheral release before the core is out of reset
  p_dom_after_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_up |=> (dom_rst_n == '0))
    else $error("p_dom_after_core_r9");

endmodule

// File: rtl/por_release_seq.sv
module por_release_seq #(
  parameter int unsigned RT_W       = 8,
  parameter int unsigned NUM_SW_DOM = 4
) (
  input  logic                  clk,
  input  logic                  ext_por_n,
  input  logic                  rail_proc_ok,
  input  logic                  rail_core_ok,
  input  logic                  rail_wkup_ok,
  input  logic                  clk_stable,
  input  logic                  memreg_ok,
  input  logic                  fuse_ready,
  input  logic [RT_W-1:0]       rst_time,
  input  logic                  sw_dsp_hold,
  input  logic [NUM_SW_DOM-1:0] sw_if_clk_en,
  output logic                  fuse_rst_n,
  output logic                  glob_por_rst_n,
  output logic                  glob_warm_rst_n,
  output logic                  pm_rst_n,
  output logic                  sysclk_en,
  output logic                  ret_rst_n,
  output logic                  pll_rst_n,
  output logic                  corepll_clk_en,
  output logic                  ic_clk_en,
  output logic                  procpll_clk_en,
  output logic                  core_rst_n,
  output logic                  proc_clk_en,
  output logic                  boot_en,
  output logic                  booted,
  output logic                  dsp_rst_n,
  output logic [NUM_SW_DOM-1:0] dom_rst_n
);
  import por_seq_pkg::*;

  seq_state_e           state_q;
  logic                 fuse_q;
  logic                 glob_q;
  logic                 booted_q;
  logic                 all_ready;
  logic                 hold_active;
  logic                 hold_expire;
  logic                 chain_adv;
  logic                 chain_done;
  logic [CHAIN_LEN-1:0] rel;

  assign all_ready   = rail_proc_ok && rail_core_ok && rail_wkup_ok &&
                       clk_stable && memreg_ok && fuse_ready;
  assign hold_active = (state_q == ST_HOLD);
  assign chain_adv   = (state_q == ST_RUN);

  por_hold_timer #(.RT_W(RT_W)) u_timer (
    .clk      (clk),
    .rst_n    (ext_por_n),
    .active   (hold_active),
    .all_ready(all_ready),
    .rst_time (rst_time),
    .expire   (hold_expire)
  );

  always_ff @(posedge clk or negedge ext_por_n) begin
    if (!ext_por_n) begin
      state_q <= ST_IDLE;
      fuse_q  <= 1'b0;
      glob_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          fuse_q  <= 1'b1;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (hold_expire) begin
            glob_q  <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  por_release_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk    (clk),
    .rst_n  (ext_por_n),
    .advance(chain_adv),
    .rel    (rel),
    .done   (chain_done)
  );

  always_ff @(posedge clk or negedge ext_por_n) begin
    if (!ext_por_n) begin
      booted_q <= 1'b0;
    end else if (chain_done) begin
      booted_q <= 1'b1;
    end
  end

  por_domain_gate #(.NUM_DOM(NUM_SW_DOM)) u_dom (
    .clk      (clk),
    .rst_n    (ext_por_n),
    .core_up  (rel[IDX_CORE]),
    .dsp_hold (sw_dsp_hold),
    .if_clk_en(sw_if_clk_en),
    .dsp_rst_n(dsp_rst_n),
    .dom_rst_n(dom_rst_n)
  );

  assign fuse_rst_n      = fuse_q;
  assign glob_por_rst_n  = glob_q;
  assign glob_warm_rst_n = glob_q;
  assign pm_rst_n        = rel[IDX_PM];
  assign sysclk_en       = rel[IDX_SYSCLK];
  assign ret_rst_n       = rel[IDX_RET];
  assign pll_rst_n       = rel[IDX_PLL];
  assign corepll_clk_en  = rel[IDX_COREPLL];
  assign ic_clk_en       = rel[IDX_IC];
  assign procpll_clk_en  = rel[IDX_PROCPLL];
  assign core_rst_n      = rel[IDX_CORE];
  assign proc_clk_en     = rel[IDX_PROCCLK];
  assign boot_en         = rel[IDX_BOOT];
  assign booted          = booted_q;

  // R2: the fuse array is out of reset before the global release
  p_fuse_first_r2: assert property (@(posedge clk) disable iff (!ext_por_n)
    $rose(glob_q) |-> $past(fuse_q))
    else $error("p_fuse_first_r2");

  // R3: global release only on an edge where every flag was high
  p_glob_ready_r3: assert property (@(posedge clk) disable iff (!ext_por_n)
    $rose(glob_q) |-> $past(all_ready))
    else $error("p_glob_ready_r3");

  // R4: a dropped flag during the hold blocks release on that edge
  p_no_release_on_drop_r4: assert property (@(posedge clk) disable iff (!ext_por_n)
    (hold_active && !all_ready) |=> !glob_q)
    else $error("p_no_release_on_drop_r4");

  // R6: flags cannot re-assert the global reset
  p_glob_stays_r6: assert property (@(posedge clk) disable iff (!ext_por_n)
    glob_q |=> glob_q)
    else $error("p_glob_stays_r6");

  // R5: the chain starts only after the global release
  p_chain_after_glob_r5: assert property (@(posedge clk) disable iff (!ext_por_n)
    rel[IDX_PM] |-> glob_q)
    else $error("p_chain_after_glob_r5");

  // R7: status is sticky and follows the boot enable
  p_booted_sticky_r7: assert property (@(posedge clk) disable iff (!ext_por_n)
    booted_q |=> booted_q)
    else $error("p_booted_sticky_r7");

  p_booted_after_boot_r7: assert property (@(posedge clk) disable iff (!ext_por_n)
    $rose(booted_q) |-> $past(rel[IDX_BOOT]))
    else $error("p_booted_after_boot_r7");

endmodule

// File: tb/por_release_seq_bench.sv
module por_release_seq_bench;

  localparam int unsigned RT_W   = 8;
  localparam int unsigned NDOM   = 4;
  localparam int unsigned VEC_N  = 8;
  localparam int unsigned V_RT   [VEC_N] = '{0, 1, 5, 5, 3, 20, 255, 7};
  localparam int unsigned V_DROP [VEC_N] = '{0, 0, 0, 3, 3, 10, 0, 7};

  logic            clk = 1'b0;
  logic            ext_por_n = 1'b0;
  logic [5:0]      rdy = '0;
  logic [RT_W-1:0] rst_time = '0;
  logic            sw_dsp_hold = 1'b1;
  logic [NDOM-1:0] sw_if_clk_en = '0;

  logic fuse_rst_n, glob_por_rst_n, glob_warm_rst_n, pm_rst_n, sysclk_en;
  logic ret_rst_n, pll_rst_n, corepll_clk_en, ic_clk_en, procpll_clk_en;
  logic core_rst_n, proc_clk_en, boot_en, booted, dsp_rst_n;
  logic [NDOM-1:0] dom_rst_n;
  logic [9:0]  chv;
  logic [18:0] all_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  por_release_seq #(.RT_W(RT_W), .NUM_SW_DOM(NDOM)) u_por_release_seq (
    .clk(clk), .ext_por_n(ext_por_n),
    .rail_proc_ok(rdy[0]), .rail_core_ok(rdy[1]), .rail_wkup_ok(rdy[2]),
    .clk_stable(rdy[3]), .memreg_ok(rdy[4]), .fuse_ready(rdy[5]),
    .rst_time(rst_time), .sw_dsp_hold(sw_dsp_hold), .sw_if_clk_en(sw_if_clk_en),
    .fuse_rst_n(fuse_rst_n), .glob_por_rst_n(glob_por_rst_n),
    .glob_warm_rst_n(glob_warm_rst_n), .pm_rst_n(pm_rst_n), .sysclk_en(sysclk_en),
    .ret_rst_n(ret_rst_n), .pll_rst_n(pll_rst_n), .corepll_clk_en(corepll_clk_en),
    .ic_clk_en(ic_clk_en), .procpll_clk_en(procpll_clk_en), .core_rst_n(core_rst_n),
    .proc_clk_en(proc_clk_en), .boot_en(boot_en), .booted(booted),
    .dsp_rst_n(dsp_rst_n), .dom_rst_n(dom_rst_n)
  );

  assign chv = {boot_en, proc_clk_en, core_rst_n, procpll_clk_en, ic_clk_en,
                corepll_clk_en, pll_rst_n, ret_rst_n, sysclk_en, pm_rst_n};
  assign all_out = {dom_rst_n, dsp_rst_n, booted, chv, glob_warm_rst_n,
                    glob_por_rst_n, fuse_rst_n};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bench restatement of the wait: zero behaves as one; a drop at edge d adds d.
  function automatic int release_edge(input int unsigned rt, input int unsigned d);
    int unsigned base;
    base = (rt < 1) ? 1 : rt;
    return int'(base + d);
  endfunction

  task automatic go_reset();
    @(negedge clk);
    ext_por_n = 1'b0;
    rdy = '0;
    sw_dsp_hold = 1'b1;
    sw_if_clk_en = '0;
    @(negedge clk);
    check("R1 reset outputs", 32'(all_out), 32'h0);
  endtask

  task automatic run_seq(input int unsigned rt, input int unsigned drop,
                         input int unsigned flag, input bit sw_open,
                         input int unsigned abort_at);
    int got;
    rst_time = RT_W'(rt);
    rdy = 6'h3F;
    if (sw_open) begin
      sw_dsp_hold = 1'b0;
      sw_if_clk_en = '1;
    end
    ext_por_n = 1'b1;
    @(negedge clk);
    check("R2 fuse released at E0", 32'(fuse_rst_n), 32'h1);
    check("R2 global held at E0", 32'({glob_por_rst_n, glob_warm_rst_n}), 32'h0);
    got = -1;
    for (int k = 1; k < 600; k++) begin
      rdy = 6'h3F;
      if (k == int'(drop)) rdy[flag] = 1'b0;
      @(negedge clk);
      if (glob_por_rst_n === 1'b1) begin
        got = k;
        break;
      end
    end
    rdy = 6'h3F;
    check(drop != 0 ? "R4 restart release edge" : "R3 release edge",
          32'(got), 32'(release_edge(rt, drop)));
    check("R3 warm reset with power-on", 32'(glob_warm_rst_n), 32'h1);
    check("R5 chain idle at release", 32'(chv), 32'h0);
    for (int s = 1; s <= 10; s++) begin
      @(negedge clk);
      if (s == int'(abort_at)) begin
        #2 ext_por_n = 1'b0;
        #1 check("R1 async return to reset", 32'(all_out), 32'h0);
        return;
      end
      check("R5 chain step", 32'(chv), 32'((1 << s) - 1));
      if (sw_open) begin
        check("R8 dsp follows core", 32'(dsp_rst_n), 32'(s >= 9));
        check("R9 domains follow core", 32'(dom_rst_n), (s >= 9) ? 32'hF : 32'h0);
      end else begin
        check("R8 dsp held", 32'(dsp_rst_n), 32'h0);
      end
      if (s == 10) check("R7 booted one edge late", 32'(booted), 32'h0);
    end
    @(negedge clk);
    check("R7 booted set", 32'(booted), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 check("R1 reset at start", 32'(all_out), 32'h0);
    // Table of wait lengths and drop edges
    for (int i = 0; i < int'(VEC_N); i++) begin
      go_reset();
      run_seq(V_RT[i], V_DROP[i], i % 6, 1'b0, 0);
    end

    // R6: dropping flags after release changes nothing
    @(negedge clk);
    rdy = '0;
    repeat (3) @(negedge clk);
    check("R6 chain unaffected", 32'(chv), 32'h3FF);
    check("R6 globals unaffected", 32'({glob_por_rst_n, glob_warm_rst_n}), 32'h3);
    check("R7 booted sticky", 32'(booted), 32'h1);

    // R8 / R9 software releases after boot
    sw_dsp_hold = 1'b0;
    @(negedge clk);
    check("R8 dsp released", 32'(dsp_rst_n), 32'h1);
    sw_if_clk_en = 4'b0100;
    @(negedge clk);
    check("R9 graphics only", 32'(dom_rst_n), 32'h4);
    sw_if_clk_en = 4'b0000;
    sw_dsp_hold = 1'b1;
    @(negedge clk);
    check("R9 domain back in reset", 32'(dom_rst_n), 32'h0);
    check("R8 dsp back in reset", 32'(dsp_rst_n), 32'h0);

    // R8 / R9 requests present from the start wait for the core release
    go_reset();
    run_seq(2, 0, 0, 1'b1, 0);

    // R1 asynchronous reset in the middle of the chain
    go_reset();
    run_seq(1, 0, 0, 1'b0, 4);
    @(negedge clk);
    check("R1 held after mid-chain reset", 32'(all_out), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule